// File: doc/BRIEF.md
# External Multiplexer Serial Command Sender

This block sends a select word to an off-chip analog multiplexer over a three-wire serial link: a data line, a gated shift clock and an active-low latch strobe. The shift rate is the fabric clock divided by a programmable ratio from 1 to 8. The ratio code is captured when a transfer starts, so changing it later has no effect on a transfer already in progress.

The word comes from one of two sources. In manual mode, a host write of a 15-bit payload starts a transfer. In auto mode, the auto-sequencer supplies a 7-bit per-slot code together with a go pulse. Bits leave MSB first. After the last bit, the strobe goes low for one shift period. The block then drops busy, raises done and sets a completion flag, which drives the interrupt request when its enable is set.

Top module: `emux_sender`

## Requirements
- R1: After reset, busy, done and irq are 0, ser_clk is 0 and ser_latch_n is 1.
- R2: With ratio code N on div_code at the start edge, ser_clk pulses are one fabric cycle wide. The first pulse falls in the N+1th cycle after the start edge, and each later pulse follows the previous one by N+1 cycles.
- R3: With auto_mode=0, a host_wr pulse sends all 15 bits of host_data MSB first. Each bit is valid on ser_dat while ser_clk is high.
- R4: With auto_mode=1, a slot_go pulse sends the 7 bits of slot_code MSB first, and only 7 ser_clk pulses occur.
- R5: slot_go has no effect when auto_mode=0, and host_wr has no effect when auto_mode=1. In both cases busy stays 0.
- R6: A start request that arrives while busy is ignored. The transfer in progress keeps its word and bit count.
- R7: After the last bit, ser_latch_n is low for exactly N+1 cycles with no ser_clk pulse. In the cycle after the strobe ends, busy is 0 and done is 1.
- R8: busy is 1 from the cycle after the start edge until the strobe ends. done reads 0 from the cycle after a new start.
- R9: Completion sets an interrupt flag. irq equals that flag ANDed with irq_en, and a one-cycle irq_clr pulse clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_code | input | 3 | Shift clock ratio code N (ratio N+1) |
| auto_mode | input | 1 | Source select: 0 host word, 1 sequencer code |
| host_wr | input | 1 | Host data write strobe (starts transfer in manual mode) |
| host_data | input | 15 | Host payload |
| slot_go | input | 1 | Sequencer start pulse (auto mode) |
| slot_code | input | 7 | Sequencer per-slot code |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one clear of the completion flag |
| ser_clk | output | 1 | Gated serial shift clock |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_latch_n | output | 1 | Active-low latch strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer fully sent |
| irq | output | 1 | Completion interrupt request |

## Verification
The assertions assume that every input is synchronous to clk and that rst_n is held low across at least one rising edge. They do not require div_code to stay stable, because the block keeps its own copy for the length of each transfer. The bench changes inputs only at falling edges and holds each start and clear strobe for one cycle. It also drives a deliberate second start during a transfer, and a start with the wrong source for the mode, to exercise the paths that must ignore them.

// File: rtl/emux_pkg.sv
package emux_pkg;
  localparam int unsigned DIV_W = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_LATCH} phase_t;

  // a shift period ends when the counter reaches the ratio code
  function automatic logic period_end(input logic [DIV_W-1:0] cnt,
                                      input logic [DIV_W-1:0] code);
    return cnt == code;
  endfunction

  function automatic logic [DIV_W-1:0] next_count(input logic [DIV_W-1:0] cnt,
                                                  input logic [DIV_W-1:0] code);
    return period_end(cnt, code) ? '0 : cnt + 1'b1;
  endfunction
endpackage

// File: rtl/emux_tick.sv
module emux_tick
  import emux_pkg::*;
#(
  parameter int unsigned CW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] code,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else                cnt <= next_count(cnt, code);
  end

  assign tick = run && period_end(cnt, code);
endmodule

// File: rtl/emux_shift.sv
module emux_shift
  import emux_pkg::*;
#(
  parameter int unsigned W  = 15,
  parameter int unsigned LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_word,
  input  logic [LW-1:0] load_len,
  input  logic          tick,
  output logic          ser_clk,
  output logic          ser_dat,
  output logic          latch_n,
  output logic          active,
  output logic          finish
);
  phase_t        phase;
  logic [W-1:0]  shreg;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      shreg <= '0;
      left  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (load) begin
          phase <= PH_DATA;
          shreg <= load_word;
          left  <= load_len;
        end
        PH_DATA: if (tick) begin
          shreg <= shreg << 1;
          left  <= left - 1'b1;
          if (left == LW'(1)) phase <= PH_LATCH;
        end
        PH_LATCH: if (tick) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign active  = phase != PH_IDLE;
  assign ser_clk = (phase == PH_DATA) && tick;
  assign ser_dat = (phase == PH_DATA) ? shreg[W-1] : 1'b0;
  assign latch_n = phase != PH_LATCH;
  assign finish  = (phase == PH_LATCH) && tick;
endmodule

// File: rtl/emux_sender.sv
module emux_sender
  import emux_pkg::*;
#(
  parameter int unsigned HOST_W = 15,
  parameter int unsigned SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_code,
  input  logic              auto_mode,
  input  logic              host_wr,
  input  logic [HOST_W-1:0] host_data,
  input  logic              slot_go,
  input  logic [SLOT_W-1:0] slot_code,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              ser_latch_n,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  localparam int unsigned LEN_W = $clog2(HOST_W + 1);
  localparam int unsigned PAD_W = HOST_W - SLOT_W;

  logic              start_req, xfer_start, xfer_end, shift_tick, irq_flag;
  logic [DIV_W-1:0]  div_hold;
  logic [HOST_W-1:0] word_sel;
  logic [LEN_W-1:0]  len_sel;

  assign start_req  = auto_mode ? slot_go : host_wr;
  assign xfer_start = start_req && !busy;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_sel = auto_mode ? {slot_code, {PAD_W{1'b0}}} : host_data;
    end else begin : g_nopad
      assign word_sel = auto_mode ? slot_code[SLOT_W-1 -: HOST_W] : host_data;
    end
  endgenerate
  assign len_sel = auto_mode ? LEN_W'(SLOT_W) : LEN_W'(HOST_W);

  always_ff @(posedge clk) begin
    if (!rst_n)          div_hold <= '0;
    else if (xfer_start) div_hold <= div_code;
  end

  emux_tick #(.CW(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .code (div_hold),
    .tick (shift_tick)
  );

  emux_shift #(.W(HOST_W), .LW(LEN_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (xfer_start),
    .load_word(word_sel),
    .load_len (len_sel),
    .tick     (shift_tick),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .latch_n  (ser_latch_n),
    .active   (busy),
    .finish   (xfer_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      if (xfer_start)    done <= 1'b0;
      else if (xfer_end) done <= 1'b1;
      if (xfer_end)      irq_flag <= 1'b1;
      else if (irq_clr)  irq_flag <= 1'b0;
    end
  end

  assign irq = irq_flag && irq_en;
endmodule

// File: rtl/emux_sender_chk.sv
module emux_sender_chk
  import emux_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ser_clk,
  input logic             ser_latch_n,
  input logic             busy,
  input logic             done,
  input logic             irq,
  input logic             irq_en,
  input logic             xfer_end,
  input logic [DIV_W-1:0] div_hold
);
  // R1: an idle link shows no clock and no strobe
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_latch_n && !ser_clk));

  // R2: for ratios above 1 the clock pulses are isolated
  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && div_hold != '0) |=> !ser_clk);

  // R7: no shift clock while the strobe is low
  p_latch_no_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_latch_n |-> !ser_clk);

  // R7: the end of the strobe leaves the block idle and done
  p_end_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> (done && !busy));

  // R8: done and busy are exclusive
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: a request only appears while enabled
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
endmodule

bind emux_sender emux_sender_chk u_chk (.*);

// File: tb/tb_emux_sender.sv
module tb_emux_sender;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  div_code = 0;
  logic        auto_mode = 0, host_wr = 0, slot_go = 0, irq_en = 0, irq_clr = 0;
  logic [14:0] host_data = 0;
  logic [6:0]  slot_code = 0;
  logic        ser_clk, ser_dat, ser_latch_n, busy, done, irq;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emux_sender dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // follows one transfer started at the edge just before the first sample
  task automatic watch(input int n, input int len, input logic [14:0] exp,
                       input bit inject);
    int cyc = 0, np = 0, firstp = 0, lastp = 0, badsp = 0, lat = 0, bsy = 0;
    logic [14:0] got = 0;
    while (cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        host_wr = 0; slot_go = 0;
        chk(done == 0, "R8 done cleared on start", done, 0);
      end
      if (inject && cyc == 3) begin host_wr = 1; slot_go = 1; host_data = 15'h7FFF; slot_code = 7'h7F; end
      if (inject && cyc == 4) begin host_wr = 0; slot_go = 0; end
      if (!busy) break;
      bsy++;
      if (ser_clk) begin
        if (np == 0) firstp = cyc;
        else if (cyc - lastp != n + 1) badsp++;
        lastp = cyc;
        got = {got[13:0], ser_dat};
        np++;
      end
      if (!ser_latch_n) lat++;
    end
    chk(firstp == n + 1, "R2 first pulse position", firstp, n + 1);
    chk(badsp == 0, "R2 pulse spacing", badsp, 0);
    chk(np == len, "R3/R4 pulse count", np, len);
    chk(got == exp, "R3/R4 shifted word", got, exp);
    chk(lat == n + 1, "R7 strobe length", lat, n + 1);
    chk(bsy == (len + 1) * (n + 1), "R8 busy length", bsy, (len + 1) * (n + 1));
    chk(done == 1 && busy == 0, "R7 done after strobe", {busy, done}, 1);
  endtask

  task automatic t_manual(input int n, input logic [14:0] d, input bit inject);
    @(negedge clk);
    div_code = 3'(n); auto_mode = 0; host_data = d; host_wr = 1;
    watch(n, 15, d, inject);
    div_code = 0;
  endtask

  task automatic t_auto(input int n, input logic [6:0] c);
    @(negedge clk);
    div_code = 3'(n); auto_mode = 1; slot_code = c; slot_go = 1;
    watch(n, 7, {8'h0, c}, 0);
    auto_mode = 0;
  endtask

  task automatic t_wrong_source;
    @(negedge clk); auto_mode = 0; slot_go = 1;
    @(negedge clk); slot_go = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R5 slot_go ignored in manual", busy, 0);
    auto_mode = 1; host_wr = 1;
    @(negedge clk); host_wr = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && ser_latch_n == 1, "R5 host_wr ignored in auto", busy, 0);
    auto_mode = 0;
  endtask

  task automatic t_irq;
    irq_en = 0;
    t_manual(0, 15'h0F0F, 0);
    chk(irq == 0, "R9 irq masked", irq, 0);
    @(negedge clk); irq_en = 1;
    #1 chk(irq == 1, "R9 irq enabled after completion", irq, 1);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk(irq == 0, "R9 irq cleared", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && irq == 0, "R1 reset status", {busy, done, irq}, 0);
    chk(ser_clk == 0 && ser_latch_n == 1, "R1 reset link", {ser_clk, ser_latch_n}, 1);
    rst_n = 1;
    t_manual(0, 15'h5A3C, 0);
    t_manual(4, 15'h1234, 0);
    t_manual(7, 15'h4001, 0);
    t_auto(2, 7'h55);
    t_auto(5, 7'h01);
    t_wrong_source;
    t_manual(1, 15'h2C71, 1);   // R6: second request mid-transfer
    t_irq;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule